// File: doc/BRIEF.md
# Up/Down Timer Counter Core

This block is the counting heart of a general-purpose timer. A 16-bit counter advances once per timer clock while enabled. It can run in one of two families of modes. In the edge family it counts only up or only down, and the direction comes from a control bit. In the center family it sweeps from zero up to an auto-reload limit and back down again, and three variants decide in which sweep direction a compare match may raise the channel flag. Each wrap or turn-around produces a one-cycle update event. That event can load a buffered auto-reload value, and it can end a single-pulse run.

Software reaches the block through a plain write port with four word addresses: control, auto-reload, compare value and flag clear. Control readback appears on a dedicated output. There is no data stream, so no port carries a valid/ready handshake. A write is accepted in every cycle in which `wr_en` is high, and it takes effect at that clock edge. A free-running divider also produces a sample-clock enable. Dead-time and input-filter logic elsewhere use it.

Register map (word address on `wr_addr`): 0 control, 1 auto-reload, 2 compare, 3 flag clear (writing 1 in bit 0 clears the flag). Control bits: 0 run, 1 update-inhibit, 3 single-pulse, 4 count direction (1 = down), 6:5 alignment mode, 7 reload buffering, 9:8 sample divider. Bits 2 and 15:10 read as zero.

Top module: `tmr_core`

## Requirements
- R1: After reset the counter is 0, the control readback is 0x0000, and `dir_out`, `upd_evt` and `cmp_flag` are 0.
- R2: Control readback bits 2 and 15:10 are always 0, whatever value was written.
- R3: With alignment 00 and direction bit 4 = 0, the counter rises by one each enabled cycle and wraps from the reload value to 0. `upd_evt` is high for exactly the one cycle in which the counter shows that 0.
- R4: With alignment 00 and direction bit 4 = 1, the counter falls by one each cycle and wraps from 0 to the reload value with a one-cycle `upd_evt`. `dir_out` is then 1.
- R5: With alignment 01, 10 or 11, the counter starts upward from 0, turns at the reload value and turns again at 0, with `upd_evt` at each turn. `dir_out` (and readback bit 4) shows the current direction (1 = down), and writes to bit 4 do not alter it.
- R6: With control bit 7 = 0, an auto-reload write takes effect at the next count. With bit 7 = 1, the write is held in a buffer and becomes active only at the next update event.
- R7: `cmp_flag` is raised one cycle after an enabled cycle in which counter equals compare value, subject to the direction rule: alignment 01 only while counting down, 10 only while counting up, 11 and 00 in any direction.
- R8: `cmp_flag` stays set until a write of 1 to bit 0 of address 3. If that clear lands in the same cycle as a new match, the flag stays set.
- R9: While the counter runs in alignment 00, a control write with a nonzero alignment field leaves the alignment at 00. The other fields of that write are applied. When the counter is stopped, any alignment may be written.
- R10: With control bit 1 set, counter wraps still happen but raise no `upd_evt` and do not load the buffered reload value.
- R11: With control bit 3 set, the run bit clears at the first update event, and the counter then holds its value.
- R12: `smp_en` is high every cycle for divider code 00 and for the spare code 11, every 2nd cycle for code 01, and every 4th cycle for code 10.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timer clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register word address |
| wr_data | input | 16 | Register write data |
| cnt_out | output | 16 | Current counter value |
| dir_out | output | 1 | Current count direction, 1 = down |
| upd_evt | output | 1 | One-cycle update event |
| cmp_flag | output | 1 | Sticky compare flag |
| smp_en | output | 1 | Divided sample-clock enable |
| ctl_out | output | 16 | Control register readback |

## Verification
Two pairs of functions can fall in the same cycle. The first pair is a compare match and a software flag clear. The bench issues the clear write so that it is captured at the very edge where the counter sits on the compare value, then checks that the flag is still set and that a later clear empties it. The second pair is a buffered reload write and an update event, together with a single-pulse stop that coincides with a wrap. For these, the bench places the write a known number of cycles before the wrap and judges the counter's value several cycles later against the limit that must be active.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

  localparam int CTL_W = 16;

  localparam int B_RUN  = 0;
  localparam int B_UDIS = 1;
  localparam int B_OPM  = 3;
  localparam int B_DIR  = 4;
  localparam int B_ALN  = 5;
  localparam int B_SHD  = 7;
  localparam int B_DIV  = 8;

  typedef enum logic [1:0] {
    ALN_EDGE  = 2'b00,
    ALN_CDOWN = 2'b01,
    ALN_CUP   = 2'b10,
    ALN_CBOTH = 2'b11
  } aln_e;

  typedef enum logic [1:0] {
    DIV_1   = 2'b00,
    DIV_2   = 2'b01,
    DIV_4   = 2'b10,
    DIV_RSV = 2'b11
  } div_e;

  typedef enum logic [1:0] {
    RA_CTL    = 2'b00,
    RA_RELOAD = 2'b01,
    RA_CMP    = 2'b10,
    RA_FLAG   = 2'b11
  } ra_e;

  typedef struct packed {
    div_e div;
    logic shd_en;
    aln_e aln;
    logic dir;
    logic one_shot;
    logic udis;
    logic run;
  } ctl_t;

  function automatic ctl_t ctl_unpack(input logic [CTL_W-1:0] d);
    ctl_t c;
    c.div      = div_e'(d[B_DIV +: 2]);
    c.shd_en   = d[B_SHD];
    c.aln      = aln_e'(d[B_ALN +: 2]);
    c.dir      = d[B_DIR];
    c.one_shot = d[B_OPM];
    c.udis     = d[B_UDIS];
    c.run      = d[B_RUN];
    return c;
  endfunction

  function automatic logic [CTL_W-1:0] ctl_pack(input ctl_t c, input logic dir_now);
    logic [CTL_W-1:0] d;
    d = '0;
    d[B_DIV +: 2] = c.div;
    d[B_SHD]      = c.shd_en;
    d[B_ALN +: 2] = c.aln;
    d[B_DIR]      = dir_now;
    d[B_OPM]      = c.one_shot;
    d[B_UDIS]     = c.udis;
    d[B_RUN]      = c.run;
    return d;
  endfunction

endpackage

// File: rtl/tmr_regs.sv
module tmr_regs
  import tmr_pkg::*;
#(
  parameter int W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [1:0]       wr_addr,
  input  logic [W-1:0]     wr_data,
  input  logic             upd_now,
  input  logic             dir_now,
  output ctl_t             ctl_q,
  output logic [W-1:0]     arr_act,
  output logic [W-1:0]     cmp_val,
  output logic             flag_clr,
  output logic [CTL_W-1:0] ctl_rd
);

  logic   wr_ctl, wr_rel, wr_cmp;
  ctl_t   ctl_wr;
  logic [W-1:0] arr_shd;

  assign wr_ctl   = wr_en && (ra_e'(wr_addr) == RA_CTL);
  assign wr_rel   = wr_en && (ra_e'(wr_addr) == RA_RELOAD);
  assign wr_cmp   = wr_en && (ra_e'(wr_addr) == RA_CMP);
  assign flag_clr = wr_en && (ra_e'(wr_addr) == RA_FLAG) && wr_data[0];

  // Incoming control word with the alignment lock applied
  always_comb begin
    ctl_wr = ctl_unpack(wr_data[CTL_W-1:0]);
    if (ctl_q.run && ctl_q.aln == ALN_EDGE && ctl_wr.aln != ALN_EDGE)
      ctl_wr.aln = ALN_EDGE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q <= '0;
    end else if (wr_ctl) begin
      ctl_q <= ctl_wr;
    end else if (upd_now && ctl_q.one_shot) begin
      ctl_q.run <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      arr_shd <= '0;
      arr_act <= '0;
    end else begin
      if (wr_rel) arr_shd <= wr_data;
      if (wr_rel && !ctl_q.shd_en) arr_act <= wr_data;
      else if (upd_now)            arr_act <= arr_shd;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cmp_val <= '0;
    else if (wr_cmp) cmp_val <= wr_data;
  end

  assign ctl_rd = ctl_pack(ctl_q, dir_now);

  // R9
  aln_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ctl && ctl_q.run && ctl_q.aln == ALN_EDGE) |=> (ctl_q.aln == ALN_EDGE));

  // R6
  reload_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!upd_now && !wr_rel) |=> $stable(arr_act));

endmodule

// File: rtl/tmr_count.sv
module tmr_count
  import tmr_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         run,
  input  logic         dir_sw,
  input  aln_e         aln,
  input  logic         udis,
  input  logic [W-1:0] arr,
  output logic [W-1:0] cnt_q,
  output logic         dir_out,
  output logic         upd_q,
  output logic         upd_now
);

  localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

  logic         center;
  logic         dn_q, dn_n;
  logic [W-1:0] cnt_n;
  logic         wrap;

  assign center = (aln != ALN_EDGE);

  always_comb begin
    cnt_n = cnt_q;
    dn_n  = center ? dn_q : 1'b0;
    wrap  = 1'b0;
    if (run) begin
      if (!center) begin
        if (!dir_sw) begin
          if (cnt_q >= arr) begin
            cnt_n = '0;
            wrap  = 1'b1;
          end else begin
            cnt_n = cnt_q + ONE;
          end
        end else begin
          if (cnt_q == '0) begin
            cnt_n = arr;
            wrap  = 1'b1;
          end else begin
            cnt_n = cnt_q - ONE;
          end
        end
      end else if (!dn_q) begin
        if (cnt_q >= arr) begin
          cnt_n = (arr == '0) ? '0 : arr - ONE;
          dn_n  = 1'b1;
          wrap  = 1'b1;
        end else begin
          cnt_n = cnt_q + ONE;
        end
      end else begin
        if (cnt_q == '0) begin
          cnt_n = (arr == '0) ? '0 : ONE;
          dn_n  = 1'b0;
          wrap  = 1'b1;
        end else begin
          cnt_n = cnt_q - ONE;
        end
      end
    end
  end

  assign upd_now = wrap && !udis;
  assign dir_out = center ? dn_q : dir_sw;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      dn_q  <= 1'b0;
      upd_q <= 1'b0;
    end else begin
      cnt_q <= cnt_n;
      dn_q  <= dn_n;
      upd_q <= upd_now;
    end
  end

  // R3
  up_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(run && !center && !dir_sw) && upd_q) |-> (cnt_q == '0));

  // R5
  center_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && center && !dn_q && cnt_q < arr) |=> (cnt_q == $past(cnt_q) + ONE));

  // R10
  udis_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    udis |=> !upd_q);

endmodule

// File: rtl/tmr_flag.sv
module tmr_flag
  import tmr_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         run,
  input  aln_e         aln,
  input  logic         dir_in,
  input  logic [W-1:0] cnt,
  input  logic [W-1:0] cmp_val,
  input  logic         clr,
  output logic         flag_q
);

  logic dir_ok, hit;

  always_comb begin
    unique case (aln)
      ALN_CDOWN: dir_ok = dir_in;
      ALN_CUP:   dir_ok = !dir_in;
      default:   dir_ok = 1'b1;
    endcase
  end

  assign hit = run && dir_ok && (cnt == cmp_val);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   flag_q <= 1'b0;
    else if (hit) flag_q <= 1'b1;
    else if (clr) flag_q <= 1'b0;
  end

  // R8
  flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q && !clr) |=> flag_q);

  // R7
  up_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (aln == ALN_CUP && dir_in && !flag_q) |=> !flag_q);

endmodule

// File: rtl/tmr_smpdiv.sv
module tmr_smpdiv
  import tmr_pkg::*;
#(
  parameter int DW = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  div_e div,
  output logic smp_en
);

  logic [DW-1:0] dcnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) dcnt <= '0;
    else        dcnt <= dcnt + 1'b1;
  end

  always_comb begin
    unique case (div)
      DIV_2:   smp_en = dcnt[0];
      DIV_4:   smp_en = &dcnt[1:0];
      default: smp_en = 1'b1;
    endcase
  end

  // R12
  div4_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (div == DIV_4 && smp_en) |=> (!smp_en || div != DIV_4));

endmodule

// File: rtl/tmr_core.sv
module tmr_core
  import tmr_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [1:0]   wr_addr,
  input  logic [W-1:0] wr_data,
  output logic [W-1:0] cnt_out,
  output logic         dir_out,
  output logic         upd_evt,
  output logic         cmp_flag,
  output logic         smp_en,
  output logic [15:0]  ctl_out
);

  ctl_t         ctl;
  logic [W-1:0] arr_act, cmp_val;
  logic         flag_clr, upd_now, dir_now;

  tmr_regs #(.W(W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .upd_now(upd_now), .dir_now(dir_now),
    .ctl_q(ctl), .arr_act(arr_act), .cmp_val(cmp_val),
    .flag_clr(flag_clr), .ctl_rd(ctl_out)
  );

  tmr_count #(.W(W)) u_count (
    .clk(clk), .rst_n(rst_n), .run(ctl.run), .dir_sw(ctl.dir),
    .aln(ctl.aln), .udis(ctl.udis), .arr(arr_act),
    .cnt_q(cnt_out), .dir_out(dir_now), .upd_q(upd_evt), .upd_now(upd_now)
  );

  tmr_flag #(.W(W)) u_flag (
    .clk(clk), .rst_n(rst_n), .run(ctl.run), .aln(ctl.aln),
    .dir_in(dir_now), .cnt(cnt_out), .cmp_val(cmp_val),
    .clr(flag_clr), .flag_q(cmp_flag)
  );

  tmr_smpdiv #(.DW(2)) u_smpdiv (
    .clk(clk), .rst_n(rst_n), .div(ctl.div), .smp_en(smp_en)
  );

  assign dir_out = dir_now;

endmodule

// File: tb/tmr_core_bench.sv
module tmr_core_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_addr = 2'b00;
  logic [15:0] wr_data = 16'h0;
  logic [15:0] cnt_out, ctl_out;
  logic        dir_out, upd_evt, cmp_flag, smp_en;

  int n_chk = 0;
  int n_err = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  tmr_core u_tmr_core (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .cnt_out(cnt_out), .dir_out(dir_out),
    .upd_evt(upd_evt), .cmp_flag(cmp_flag), .smp_en(smp_en),
    .ctl_out(ctl_out)
  );

  // {ctrl, reload, cycles after start, cnt, dir, upd}
  localparam int NV = 11;
  localparam logic [57:0] VEC [NV] = '{
    {16'h0001, 16'd4, 8'd5, 16'd0, 1'b0, 1'b1},
    {16'h0001, 16'd4, 8'd7, 16'd2, 1'b0, 1'b0},
    {16'h0011, 16'd4, 8'd1, 16'd4, 1'b1, 1'b1},
    {16'h0011, 16'd4, 8'd3, 16'd2, 1'b1, 1'b0},
    {16'h0061, 16'd4, 8'd4, 16'd4, 1'b0, 1'b0},
    {16'h0061, 16'd4, 8'd5, 16'd3, 1'b1, 1'b1},
    {16'h0061, 16'd4, 8'd8, 16'd0, 1'b1, 1'b0},
    {16'h0061, 16'd4, 8'd9, 16'd1, 1'b0, 1'b1},
    {16'h0021, 16'd4, 8'd6, 16'd2, 1'b1, 1'b0},
    {16'h0041, 16'd3, 8'd3, 16'd3, 1'b0, 1'b0},
    {16'h0041, 16'd3, 8'd4, 16'd2, 1'b1, 1'b1}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    tick(2);
    rst_n = 1'b1;
    tick(1);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_err);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    tick(1);
    do_reset();
    // R1 reset state
    chk("R1 cnt", cnt_out, 0);
    chk("R1 ctl", ctl_out, 0);
    chk("R1 dir", dir_out, 0);
    chk("R1 upd", upd_evt, 0);
    chk("R1 flag", cmp_flag, 0);

    // R3 / R4 / R5 vector walk
    for (int i = 0; i < NV; i++) begin
      logic [15:0] vc, vr, ve;
      logic [7:0]  vk;
      logic        vd, vu;
      string       tg;
      {vc, vr, vk, ve, vd, vu} = VEC[i];
      tg = (vc[6:5] != 2'b00) ? "R5" : (vc[4] ? "R4" : "R3");
      do_reset();
      wr(2'd1, vr);
      wr(2'd0, vc);
      tick(int'(vk));
      chk($sformatf("%s vec%0d cnt", tg, i), cnt_out, ve);
      chk($sformatf("%s vec%0d dir", tg, i), dir_out, vd);
      chk($sformatf("%s vec%0d upd", tg, i), upd_evt, vu);
    end

    // R2 reserved bits
    do_reset();
    wr(2'd0, 16'hFC04);
    chk("R2 reserved only", ctl_out, 16'h0000);
    wr(2'd0, 16'hFFFE);
    chk("R2 all but run", ctl_out, 16'h03EA);

    // R5 direction bit write ignored in center mode
    do_reset();
    wr(2'd1, 16'd4);
    wr(2'd0, 16'h0071);
    tick(1);
    chk("R5 dir read-only", dir_out, 0);

    // R6 direct reload
    do_reset();
    wr(2'd1, 16'd2);
    wr(2'd0, 16'h0001);
    wr(2'd1, 16'd6);
    tick(2);
    chk("R6 direct", cnt_out, 3);

    // R6 buffered reload
    do_reset();
    wr(2'd1, 16'd2);
    wr(2'd0, 16'h0081);
    wr(2'd1, 16'd6);
    tick(2);
    chk("R6 buffered old limit", cnt_out, 0);
    chk("R6 buffered upd", upd_evt, 1);
    tick(6);
    chk("R6 buffered new limit", cnt_out, 6);
    tick(1);
    chk("R6 buffered wrap", cnt_out, 0);

    // R7 up-only mode
    do_reset();
    wr(2'd1, 16'd4); wr(2'd2, 16'd3);
    wr(2'd0, 16'h0041);
    tick(4);
    chk("R7 mode10 up hit", cmp_flag, 1);
    wr(2'd3, 16'h0001);
    chk("R7 mode10 cleared", cmp_flag, 0);
    tick(1);
    chk("R7 mode10 down ignored", cmp_flag, 0);

    // R7 both directions
    do_reset();
    wr(2'd1, 16'd4); wr(2'd2, 16'd3);
    wr(2'd0, 16'h0061);
    tick(4);
    chk("R7 mode11 up hit", cmp_flag, 1);
    wr(2'd3, 16'h0001);
    tick(1);
    chk("R7 mode11 down hit", cmp_flag, 1);

    // R7 down-only mode
    do_reset();
    wr(2'd1, 16'd4); wr(2'd2, 16'd3);
    wr(2'd0, 16'h0021);
    tick(4);
    chk("R7 mode01 up ignored", cmp_flag, 0);
    tick(2);
    chk("R7 mode01 down hit", cmp_flag, 1);

    // R8 set beats clear, sticky, clear
    do_reset();
    wr(2'd1, 16'd9); wr(2'd2, 16'd5);
    wr(2'd0, 16'h0001);
    tick(5);
    chk("R8 at match", cnt_out, 5);
    wr(2'd3, 16'h0001);
    chk("R8 set wins", cmp_flag, 1);
    tick(2);
    chk("R8 sticky", cmp_flag, 1);
    wr(2'd3, 16'h0001);
    chk("R8 cleared", cmp_flag, 0);

    // R9 alignment lock
    do_reset();
    wr(2'd1, 16'd9);
    wr(2'd0, 16'h0001);
    wr(2'd0, 16'h0061);
    chk("R9 lock", ctl_out, 16'h0001);
    chk("R9 still edge", cnt_out, 1);
    wr(2'd0, 16'h0000);
    wr(2'd0, 16'h0061);
    chk("R9 unlocked when stopped", ctl_out, 16'h0061);

    // R10 update inhibit
    do_reset();
    wr(2'd1, 16'd2);
    wr(2'd0, 16'h0083);
    wr(2'd1, 16'd6);
    tick(2);
    chk("R10 wrap cnt", cnt_out, 0);
    chk("R10 no upd", upd_evt, 0);
    tick(3);
    chk("R10 no load", cnt_out, 0);

    // R11 single pulse
    do_reset();
    wr(2'd1, 16'd2);
    wr(2'd0, 16'h0009);
    tick(3);
    chk("R11 upd", upd_evt, 1);
    chk("R11 run cleared", ctl_out[0], 0);
    tick(2);
    chk("R11 hold", cnt_out, 0);

    // R12 sample enable divider
    for (int d = 0; d < 4; d++) begin
      int cnt_en;
      int exp_en;
      do_reset();
      wr(2'd0, 16'(d << 8));
      cnt_en = 0;
      for (int c = 0; c < 8; c++) begin
        if (smp_en) cnt_en++;
        tick(1);
      end
      exp_en = (d == 1) ? 4 : ((d == 2) ? 2 : 8);
      chk($sformatf("R12 div code %0d", d), cnt_en, exp_en);
    end

    done = 1'b1;
    summary();
    $finish;
  end

endmodule